// File: doc/BRIEF.md
# Receive Destination Address Classifier

This block sits at the front of an Ethernet receive path. For every incoming frame the receive logic presents the 48-bit destination address together with a one-cycle strobe. The classifier decides whether the frame is kept, and if so on which of eight receive channels. Frame storage and DMA are handled elsewhere. The result arrives a fixed two cycles later as a valid pulse with an accept flag and a channel number.

The decision draws on four kinds of state, all loaded through a simple write port:

- **Address table.** Thirty-two entries. Each entry holds an address, a channel, a valid flag and a drop flag. A drop entry rejects its address outright. Any other valid entry steers its address to its channel.
- **Multicast hash.** A 64-bit mask that admits group addresses.
- **Unicast enables.** One enable bit per channel, with separate set and clear registers.
- **Receive configuration.** Enables and target channels for broadcast and for multicast.

Rules are applied in a fixed priority. Anything that matches no rule is dropped.

Top module: `rx_addr_classifier`

## Requirements
- R1: A synchronous active-high reset clears every table entry to invalid, the hash mask to zero, all unicast enables, and both broadcast and multicast enables. While reset is held and afterwards, res_valid and res_accept are low until a strobe is given, and any address is then dropped.
- R2: A strobe seen at a clock edge yields res_valid high for exactly one cycle, two cycles after the strobe cycle. Strobes may be given on consecutive cycles. res_valid is never high without a matching strobe.
- R3: res_accept is only high together with res_valid. Whenever res_accept is low, res_chan is 0.
- R4: Table writes use register selects. Select 0 loads the entry index from bits [4:0]. Select 1 stages address bits [47:16] from data bits [31:0]. Select 2 commits the entry at the index, taking:
  - address bits [15:0] from data [15:0];
  - channel from [18:16];
  - valid from [24];
  - drop flag from [25].
  Writes with select 0 or 1 alone leave the table unchanged.
- R5: An address equal to a valid entry whose drop flag is set is dropped, whatever any other rule would decide, broadcast included.
- R6: The all-ones address is accepted on the broadcast channel when the broadcast enable is set. Configuration select 7 carries the broadcast enable in bit 0 and the broadcast channel in [10:8]. With broadcast disabled, the all-ones address falls through to the multicast and unicast rules.
- R7: An address with bit 40 set (the group bit) is accepted on the multicast channel under two conditions. The multicast enable (select 7 bit 16; channel in [26:24]) must be set. The hash mask must also have its bit set at the hash index. The hash index is the XOR of the eight 6-bit slices address[6k+5:6k]. The mask's low half is written at select 3 and its high half at select 4. A mask of zero rejects all such addresses.
- R8: Any other address equal to a valid non-drop entry whose channel is unicast-enabled is accepted on that entry's channel. When several such entries match, the lowest index wins.
- R9: Select 5 sets, and select 6 clears, the unicast enables named by the ones in data [7:0]. A zero bit leaves its channel alone. Writing FFh with select 6 disables all channels. A match whose channel is disabled does not accept.
- R10: An address matching none of the rules above is dropped.
- R11: Entries with the valid flag clear take part in neither matching nor filtering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | 32 | Register write data |
| in_strobe | input | 1 | Destination address present |
| in_mac | input | 48 | Destination address, first octet in [47:40] |
| res_valid | output | 1 | Classification result present |
| res_accept | output | 1 | Frame kept |
| res_chan | output | 3 | Receive channel of a kept frame, else 0 |

## Verification
Each classification result is due in the second cycle after its strobe cycle. A write sampled at an edge is seen by any strobe sampled at a later edge. The bench's reference model advances a two-stage queue of expected results at every rising edge, applying writes after classifying the strobe of that same edge. At every falling edge it compares res_valid, res_accept and res_chan against the head of that queue, so idle cycles are checked as well as result cycles.

// File: rtl/rxac_pkg.sv
package rxac_pkg;
    localparam int ENTRIES   = 32;
    localparam int CHANS     = 8;
    localparam int MAC_W     = 48;
    localparam int HASH_W    = 6;
    localparam int REG_W     = 32;
    localparam int IDX_W     = $clog2(ENTRIES);
    localparam int CH_W      = $clog2(CHANS);
    localparam int HASH_N    = 1 << HASH_W;
    localparam int FOLDS     = MAC_W / HASH_W;
    localparam int LO_W      = 16;
    localparam int HI_W      = MAC_W - LO_W;
    localparam int GROUP_BIT = 40;

    // field positions inside write words
    localparam int F_CH_LSB   = 16;
    localparam int F_VALID    = 24;
    localparam int F_DROP     = 25;
    localparam int C_BC_EN    = 0;
    localparam int C_BC_CH    = 8;
    localparam int C_MC_EN    = 16;
    localparam int C_MC_CH    = 24;

    typedef logic [MAC_W-1:0] mac_t;
    typedef logic [CH_W-1:0]  chan_t;

    typedef enum logic [2:0] {
        SEL_INDEX   = 3'd0,
        SEL_ADDR_HI = 3'd1,
        SEL_ADDR_LO = 3'd2,
        SEL_HASH_LO = 3'd3,
        SEL_HASH_HI = 3'd4,
        SEL_UC_SET  = 3'd5,
        SEL_UC_CLR  = 3'd6,
        SEL_CFG     = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic  valid;
        logic  drop;
        chan_t chan;
        mac_t  mac;
    } entry_t;

    typedef struct packed {
        logic  bc_en;
        chan_t bc_ch;
        logic  mc_en;
        chan_t mc_ch;
    } rx_cfg_t;

    typedef struct packed {
        logic  valid;
        logic  filt;
        logic  bc;
        logic  mc;
        logic  uc;
        chan_t bc_ch;
        chan_t mc_ch;
        chan_t uc_ch;
    } stage_t;

    function automatic logic [HASH_W-1:0] fold_hash(input mac_t a);
        logic [HASH_W-1:0] acc;
        acc = '0;
        for (int g = 0; g < FOLDS; g++)
            acc = acc ^ a[g*HASH_W +: HASH_W];
        return acc;
    endfunction

    function automatic logic is_bcast(input mac_t a);
        return &a;
    endfunction
endpackage

// File: rtl/rxac_regs.sv
module rxac_regs
    import rxac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    output entry_t            tbl_o [ENTRIES],
    output logic [HASH_N-1:0] hash_o,
    output logic [CHANS-1:0]  uc_en_o,
    output rx_cfg_t           cfg_o
);
    logic [IDX_W-1:0] idx_q;
    logic [HI_W-1:0]  hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            hi_q    <= '0;
            hash_o  <= '0;
            uc_en_o <= '0;
            cfg_o   <= '0;
            for (int i = 0; i < ENTRIES; i++) tbl_o[i] <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_INDEX:   idx_q <= wr_data[IDX_W-1:0];
                SEL_ADDR_HI: hi_q  <= wr_data[HI_W-1:0];
                SEL_ADDR_LO: tbl_o[idx_q] <= '{valid: wr_data[F_VALID],
                                               drop:  wr_data[F_DROP],
                                               chan:  wr_data[F_CH_LSB +: CH_W],
                                               mac:   {hi_q, wr_data[LO_W-1:0]}};
                SEL_HASH_LO: hash_o[REG_W-1:0]      <= wr_data;
                SEL_HASH_HI: hash_o[HASH_N-1:REG_W] <= wr_data;
                SEL_UC_SET:  uc_en_o <= uc_en_o | wr_data[CHANS-1:0];
                SEL_UC_CLR:  uc_en_o <= uc_en_o & ~wr_data[CHANS-1:0];
                SEL_CFG:     cfg_o <= '{bc_en: wr_data[C_BC_EN],
                                        bc_ch: wr_data[C_BC_CH +: CH_W],
                                        mc_en: wr_data[C_MC_EN],
                                        mc_ch: wr_data[C_MC_CH +: CH_W]};
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rxac_match.sv
module rxac_match
    import rxac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_i,
    input  mac_t              mac_i,
    input  entry_t            tbl_i [ENTRIES],
    input  logic [HASH_N-1:0] hash_i,
    input  logic [CHANS-1:0]  uc_en_i,
    input  rx_cfg_t           cfg_i,
    output stage_t            st_o
);
    logic [ENTRIES-1:0] hit;
    logic  filt, uc;
    chan_t uc_ch;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit[g] = tbl_i[g].valid && (tbl_i[g].mac == mac_i);
    end

    // descending scan so the lowest matching index is left standing
    always_comb begin
        filt  = 1'b0;
        uc    = 1'b0;
        uc_ch = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit[i]) begin
                if (tbl_i[i].drop) begin
                    filt = 1'b1;
                end else if (uc_en_i[tbl_i[i].chan]) begin
                    uc    = 1'b1;
                    uc_ch = tbl_i[i].chan;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_o <= '0;
        end else begin
            st_o <= '{valid: strobe_i,
                      filt:  filt,
                      bc:    is_bcast(mac_i) && cfg_i.bc_en,
                      mc:    mac_i[GROUP_BIT] && cfg_i.mc_en && hash_i[fold_hash(mac_i)],
                      uc:    uc,
                      bc_ch: cfg_i.bc_ch,
                      mc_ch: cfg_i.mc_ch,
                      uc_ch: uc_ch};
        end
    end
endmodule

// File: rtl/rxac_decide.sv
module rxac_decide
    import rxac_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  stage_t st_i,
    output logic   res_valid_o,
    output logic   res_accept_o,
    output chan_t  res_chan_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid_o  <= 1'b0;
            res_accept_o <= 1'b0;
            res_chan_o   <= '0;
        end else begin
            res_valid_o  <= st_i.valid;
            res_accept_o <= 1'b0;
            res_chan_o   <= '0;
            if (st_i.valid && !st_i.filt) begin
                if (st_i.bc) begin
                    res_accept_o <= 1'b1;
                    res_chan_o   <= st_i.bc_ch;
                end else if (st_i.mc) begin
                    res_accept_o <= 1'b1;
                    res_chan_o   <= st_i.mc_ch;
                end else if (st_i.uc) begin
                    res_accept_o <= 1'b1;
                    res_chan_o   <= st_i.uc_ch;
                end
            end
        end
    end
endmodule

// File: rtl/rx_addr_classifier.sv
module rx_addr_classifier
    import rxac_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [2:0]            wr_sel,
    input  logic [REG_W-1:0]      wr_data,
    input  logic                  in_strobe,
    input  logic [MAC_W-1:0]      in_mac,
    output logic                  res_valid,
    output logic                  res_accept,
    output logic [CH_W-1:0]       res_chan
);
    entry_t            tbl [ENTRIES];
    logic [HASH_N-1:0] hash;
    logic [CHANS-1:0]  uc_en;
    rx_cfg_t           cfg;
    stage_t            st;

    rxac_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .tbl_o   (tbl),
        .hash_o  (hash),
        .uc_en_o (uc_en),
        .cfg_o   (cfg)
    );

    rxac_match u_match (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (in_strobe),
        .mac_i    (in_mac),
        .tbl_i    (tbl),
        .hash_i   (hash),
        .uc_en_i  (uc_en),
        .cfg_i    (cfg),
        .st_o     (st)
    );

    rxac_decide u_decide (
        .clk          (clk),
        .rst          (rst),
        .st_i         (st),
        .res_valid_o  (res_valid),
        .res_accept_o (res_accept),
        .res_chan_o   (res_chan)
    );
endmodule

// File: rtl/rxac_checker.sv
module rxac_checker
    import rxac_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            in_strobe,
    input logic            res_valid,
    input logic            res_accept,
    input logic [CH_W-1:0] res_chan
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R2: result pulse exactly two cycles behind its strobe
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (res_valid == $past(in_strobe, 2)));

    // R3: accept never without valid
    p_accept_valid_r3: assert property (@(posedge clk) disable iff (rst)
        res_accept |-> res_valid);

    // R3: dropped results report channel zero
    p_drop_chan_r3: assert property (@(posedge clk) disable iff (rst)
        !res_accept |-> (res_chan == '0));

    // R1: outputs quiet right after reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!res_valid && !res_accept));
endmodule

bind rx_addr_classifier rxac_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_strobe  (in_strobe),
    .res_valid  (res_valid),
    .res_accept (res_accept),
    .res_chan   (res_chan)
);

// File: tb/sim_rx_addr_classifier.sv
`timescale 1ns/1ps
module sim_rx_addr_classifier;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        in_strobe = 1'b0;
    logic [47:0] in_mac = '0;
    logic        res_valid, res_accept;
    logic [2:0]  res_chan;
    string       cur_tag = "R2";

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    rx_addr_classifier u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .in_strobe(in_strobe), .in_mac(in_mac),
        .res_valid(res_valid), .res_accept(res_accept), .res_chan(res_chan)
    );

    // ---------------- reference model ----------------
    logic [47:0] m_addr [32];
    int          m_ch   [32];
    bit          m_v    [32];
    bit          m_f    [32];
    logic [63:0] m_hash;
    logic [7:0]  m_uc;
    bit          m_bce, m_mce;
    int          m_bcc, m_mcc;
    int          m_idx;
    logic [31:0] m_hi;

    bit    p1_v, p1_a, p2_v, p2_a;
    int    p1_c, p2_c;
    string p1_t, p2_t;

    function automatic int ref_hash(input logic [47:0] a);
        int h = 0;
        for (int j = 0; j < 6; j++) begin
            bit b = 0;
            for (int k = 0; k < 8; k++) b ^= a[k*6+j];
            if (b) h += (1 << j);
        end
        return h;
    endfunction

    function automatic void classify(input logic [47:0] a, output bit acc, output int ch);
        acc = 0; ch = 0;
        for (int i = 0; i < 32; i++)
            if (m_v[i] && m_f[i] && m_addr[i] == a) return;
        if (a == {48{1'b1}} && m_bce) begin acc = 1; ch = m_bcc; return; end
        if (a[40] && m_mce && m_hash[ref_hash(a)]) begin acc = 1; ch = m_mcc; return; end
        for (int i = 0; i < 32; i++)
            if (m_v[i] && !m_f[i] && m_addr[i] == a && m_uc[m_ch[i]]) begin
                acc = 1; ch = m_ch[i]; return;
            end
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 32; i++) begin
                m_addr[i] = '0; m_ch[i] = 0; m_v[i] = 0; m_f[i] = 0;
            end
            m_hash = '0; m_uc = '0; m_bce = 0; m_mce = 0; m_bcc = 0; m_mcc = 0;
            m_idx = 0; m_hi = '0;
            p1_v = 0; p1_a = 0; p1_c = 0; p2_v = 0; p2_a = 0; p2_c = 0;
            p1_t = "R1"; p2_t = "R1";
        end else begin
            p2_v = p1_v; p2_a = p1_a; p2_c = p1_c; p2_t = p1_t;
            p1_v = in_strobe; p1_a = 0; p1_c = 0; p1_t = cur_tag;
            if (in_strobe) classify(in_mac, p1_a, p1_c);
            if (wr_en) begin
                case (wr_sel)
                    3'd0: m_idx = int'(wr_data[4:0]);
                    3'd1: m_hi = wr_data;
                    3'd2: begin
                        m_addr[m_idx] = {m_hi, wr_data[15:0]};
                        m_ch[m_idx]   = int'(wr_data[18:16]);
                        m_v[m_idx]    = wr_data[24];
                        m_f[m_idx]    = wr_data[25];
                    end
                    3'd3: m_hash[31:0]  = wr_data;
                    3'd4: m_hash[63:32] = wr_data;
                    3'd5: m_uc = m_uc | wr_data[7:0];
                    3'd6: m_uc = m_uc & ~wr_data[7:0];
                    default: begin
                        m_bce = wr_data[0];  m_bcc = int'(wr_data[10:8]);
                        m_mce = wr_data[16]; m_mcc = int'(wr_data[26:24]);
                    end
                endcase
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (res_valid !== p2_v) begin
                fails++;
                $display("FAIL R2 (%s): res_valid=%0b expected %0b", p2_t, res_valid, p2_v);
            end
            if (p2_v) begin
                checks++;
                if (res_accept !== p2_a || int'(res_chan) != (p2_a ? p2_c : 0)) begin
                    fails++;
                    $display("FAIL %s: accept/chan=%0b/%0d expected %0b/%0d",
                             p2_t, res_accept, res_chan, p2_a, p2_c);
                end
            end else begin
                checks++;
                if (res_accept !== 1'b0 || res_chan !== 3'd0) begin
                    fails++;
                    $display("FAIL R3: idle accept/chan=%0b/%0d expected 0/0", res_accept, res_chan);
                end
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input int sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic prog(input int idx, input logic [47:0] a, input int ch, input bit v, input bit f);
        wr(0, 32'(idx));
        wr(1, a[47:16]);
        wr(2, {6'b0, f, v, 5'b0, 3'(ch), a[15:0]});
    endtask

    function automatic logic [31:0] cfgw(input bit bce, input int bcc, input bit mce, input int mcc);
        return {5'b0, 3'(mcc), 7'b0, mce, 5'b0, 3'(bcc), 7'b0, bce};
    endfunction

    task automatic probe(input logic [47:0] a, input string tag);
        @(negedge clk);
        in_strobe = 1'b1; in_mac = a; cur_tag = tag;
        @(negedge clk);
        in_strobe = 1'b0; cur_tag = "R2";
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    localparam logic [47:0] A  = 48'h02_11_22_33_44_55;
    localparam logic [47:0] B  = 48'h04_aa_bb_cc_dd_ee;
    localparam logic [47:0] M  = 48'h01_00_5e_00_00_fb;
    localparam logic [47:0] M2 = 48'h33_33_00_00_00_01;
    localparam logic [47:0] BC = 48'hff_ff_ff_ff_ff_ff;
    localparam logic [47:0] U  = 48'h06_00_00_00_00_01;

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_accept !== 1'b0) begin
            fails++;
            $display("FAIL R1: after reset valid/accept=%0b/%0b expected 0/0", res_valid, res_accept);
        end
        probe(BC, "R1");
        probe(A, "R1");

        // unicast table and enables
        prog(0, A, 3, 1, 0);
        probe(A, "R9");
        wr(5, 32'h08);
        probe(A, "R8");
        wr(0, 0); wr(1, 32'hdead_beef);
        probe(A, "R4");
        prog(1, A, 5, 1, 0);
        wr(5, 32'h20);
        probe(A, "R8");
        wr(6, 32'h08);
        probe(A, "R9");
        wr(6, 32'hFF);
        probe(A, "R9");
        wr(5, 32'h28);

        // invalid entries
        prog(2, B, 2, 0, 0);
        wr(5, 32'hFF);
        probe(B, "R11");
        prog(2, B, 2, 1, 0);
        probe(B, "R11");

        // broadcast and filter entries
        wr(7, cfgw(1, 6, 0, 0));
        probe(BC, "R6");
        prog(3, BC, 0, 1, 1);
        probe(BC, "R5");
        prog(3, BC, 0, 0, 1);
        prog(4, A, 0, 1, 1);
        probe(A, "R5");
        prog(4, A, 0, 0, 1);
        probe(A, "R11");

        // multicast hash
        wr(7, cfgw(1, 6, 1, 1));
        probe(M, "R7");
        if (ref_hash(M) < 32) wr(3, 32'h1 << ref_hash(M));
        else                  wr(4, 32'h1 << (ref_hash(M) - 32));
        probe(M, "R7");
        probe(M2, "R7");
        wr(3, 32'h0); wr(4, 32'h0);
        probe(M, "R7");
        wr(3, 32'hFFFF_FFFF); wr(4, 32'hFFFF_FFFF);
        probe(M2, "R7");
        probe(BC, "R6");
        wr(7, cfgw(0, 6, 1, 1));
        probe(BC, "R6");

        // no-match drops
        probe(U, "R10");
        wr(7, 32'h0);
        probe(M, "R10");

        // back-to-back strobes
        @(negedge clk);
        in_strobe = 1'b1; in_mac = A;  cur_tag = "R2";
        @(negedge clk); in_mac = B;
        @(negedge clk); in_mac = BC;
        @(negedge clk); in_mac = U;
        @(negedge clk); in_strobe = 1'b0;
        repeat (3) @(negedge clk);

        // second reset wipes state
        do_reset();
        probe(A, "R1");
        wr(5, 32'hFF);
        probe(A, "R1");
        probe(B, "R1");

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2: watchdog expired, run did not finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule